// File: doc/BRIEF.md
# Fixed-Point PI Compensator with Conditional Integration

This block is a discrete-time proportional-integral compensator for power-converter control loops (phase current, DC-link voltage, grid-angle tracking). It takes one signed error sample each time a strobe is raised and produces one signed control value. The proportional path and the integral path are kept apart. When the output would leave its range, the integral path can be frozen for that sample.

The integrator uses the trapezoidal rule. It keeps a running sum `s` of the current and previous error. The caller scales this sum by the gain `kh`, which stands for ki·Ts/2. If the tentative output falls outside the programmed window, the block discards that sample's integrator update. It then rebuilds the output from the held integrator value and clamps the result to the window. Gains are signed Q-format numbers with `FRAC` fractional bits. The loop sample rate (10 kHz in the intended use) sets only how often the strobe is raised.

Top module: `pi_aw_ctrl`

## Requirements
- R1: A synchronous reset clears the previous-error register, the integrator and the output register to zero and drops `ctl_vld`. The first sample after reset therefore uses a previous error of 0 and a previous integrator value of 0.
- R2: A strobe sampled high on one rising edge is reflected on the next rising edge, where `ctl_out` updates and `ctl_vld` is high for exactly one cycle. Strobes on consecutive cycles are each processed in order.
- R3: For each sample, the tentative integrator is s_new = s_prev + e_k + e_prev, where e_prev is the error of the previous sample.
- R4: The tentative output is floor((kp·e_k + kh·s_new) / 2^FRAC). The gains `kp_in` and `kh_in` are signed, with FRAC fractional bits.
- R5: If the tentative output is greater than `lim_hi` or less than `lim_lo`, the integrator keeps s_prev. The output is then recomputed as floor((kp·e_k + kh·s_prev) / 2^FRAC).
- R6: The recomputed output is clamped: values above `lim_hi` give `lim_hi`, and values below `lim_lo` give `lim_lo`. The caller keeps lim_lo ≤ lim_hi.
- R7: The integrator is a signed ACC_W-bit value that saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) instead of wrapping.
- R8: Between samples, `ctl_out` holds its last value and `ctl_vld` is low. Changes on `err_in`, the gains and the limits without a strobe have no effect.
- R9: The previous-error register takes the current error on every sample, including samples where the integrator is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| err_in | input | EW | Signed error sample |
| kp_in | input | CW | Proportional gain, signed, FRAC fractional bits |
| kh_in | input | CW | Integral gain times half the sample period, signed, FRAC fractional bits |
| lim_lo | input | YW | Lower output limit, signed |
| lim_hi | input | YW | Upper output limit, signed |
| ctl_out | output | YW | Signed control value |
| ctl_vld | output | 1 | High for one cycle when a new control value is presented |

## Verification
The hardest state to reach from the ports is a saturated integrator. The output window normally freezes the integrator long before its wide sum can reach either rail. The stimulus sets both gains to zero so that no sample clips, then drives full-scale error for a long run of back-to-back strobes. The bench uses a narrowed accumulator to keep this run short. It then switches to a tiny integral gain with zero error, so the saturated sum shows up directly on the output. The same is done at the negative rail.

// File: rtl/pi_pkg.sv
package pi_pkg;

    typedef enum logic [1:0] {
        LIM_NONE = 2'd0,
        LIM_HIGH = 2'd1,
        LIM_LOW  = 2'd2
    } lim_e;

endpackage

// File: rtl/pi_integ.sv
module pi_integ #(
    parameter int EW    = 16,
    parameter int ACC_W = 48
) (
    input  logic signed [ACC_W-1:0] s_prev,
    input  logic signed [EW-1:0]    e_cur,
    input  logic signed [EW-1:0]    e_old,
    output logic signed [ACC_W-1:0] s_next
);
    localparam int XW = ACC_W + 1;

    logic signed [XW-1:0] sum_x;

    always_comb begin
        sum_x = XW'(s_prev) + XW'(e_cur) + XW'(e_old);
        if (sum_x[XW-1] != sum_x[XW-2]) begin
            s_next = sum_x[XW-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                 : {1'b0, {(ACC_W-1){1'b1}}};
        end else begin
            s_next = sum_x[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/pi_mac.sv
module pi_mac #(
    parameter int EW    = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 48,
    parameter int FRAC  = 12,
    parameter int SW    = 66
) (
    input  logic signed [CW-1:0]    kp,
    input  logic signed [CW-1:0]    kh,
    input  logic signed [EW-1:0]    e,
    input  logic signed [ACC_W-1:0] s,
    output logic signed [SW-1:0]    y
);
    logic signed [SW-1:0] kp_x, kh_x, e_x, s_x, acc;

    always_comb begin
        kp_x = SW'(kp);
        kh_x = SW'(kh);
        e_x  = SW'(e);
        s_x  = SW'(s);
        acc  = (kp_x * e_x) + (kh_x * s_x);
        y    = acc >>> FRAC;
    end

endmodule

// File: rtl/pi_limit.sv
module pi_limit #(
    parameter int YW = 16,
    parameter int SW = 66
) (
    input  logic signed [SW-1:0] v,
    input  logic signed [YW-1:0] lo,
    input  logic signed [YW-1:0] hi,
    output pi_pkg::lim_e         st,
    output logic signed [YW-1:0] y
);
    logic signed [SW-1:0] lo_x, hi_x;

    always_comb begin
        lo_x = SW'(lo);
        hi_x = SW'(hi);
        if (v > hi_x) begin
            st = pi_pkg::LIM_HIGH;
            y  = hi;
        end else if (v < lo_x) begin
            st = pi_pkg::LIM_LOW;
            y  = lo;
        end else begin
            st = pi_pkg::LIM_NONE;
            y  = v[YW-1:0];
        end
    end

endmodule

// File: rtl/pi_aw_ctrl.sv
module pi_aw_ctrl #(
    parameter int EW    = 16,
    parameter int CW    = 16,
    parameter int YW    = 16,
    parameter int FRAC  = 12,
    parameter int ACC_W = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [EW-1:0] err_in,
    input  logic signed [CW-1:0] kp_in,
    input  logic signed [CW-1:0] kh_in,
    input  logic signed [YW-1:0] lim_lo,
    input  logic signed [YW-1:0] lim_hi,
    output logic signed [YW-1:0] ctl_out,
    output logic                 ctl_vld
);
    localparam int SW    = CW + ACC_W + 2;
    localparam int NCAND = 2;

    typedef struct packed {
        logic                 vld;
        logic signed [EW-1:0] e;
        logic signed [CW-1:0] kp;
        logic signed [CW-1:0] kh;
        logic signed [YW-1:0] lo;
        logic signed [YW-1:0] hi;
    } cap_t;

    typedef struct packed {
        cap_t                    cap;
        logic signed [EW-1:0]    e_prev;
        logic signed [ACC_W-1:0] integ;
        logic signed [YW-1:0]    y;
        logic                    vld;
    } state_t;

    state_t st_d, st_q;

    logic signed [ACC_W-1:0] integ_new;
    logic signed [ACC_W-1:0] cand_s [NCAND];
    logic signed [SW-1:0]    mac_y  [NCAND];
    logic signed [YW-1:0]    lim_y  [NCAND];
    pi_pkg::lim_e            lim_st [NCAND];
    logic                    clip;
    logic                    held_clip;

    logic                    cap_vld_q;
    logic signed [EW-1:0]    cap_e_q;
    logic signed [EW-1:0]    e_prev_q;
    logic signed [ACC_W-1:0] integ_q;

    pi_integ #(.EW(EW), .ACC_W(ACC_W)) u_integ (
        .s_prev (st_q.integ),
        .e_cur  (st_q.cap.e),
        .e_old  (st_q.e_prev),
        .s_next (integ_new)
    );

    // candidate 0: updated integrator, candidate 1: held integrator
    assign cand_s[0] = integ_new;
    assign cand_s[1] = st_q.integ;

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        pi_mac #(
            .EW(EW), .CW(CW), .ACC_W(ACC_W), .FRAC(FRAC), .SW(SW)
        ) u_mac (
            .kp (st_q.cap.kp),
            .kh (st_q.cap.kh),
            .e  (st_q.cap.e),
            .s  (cand_s[g]),
            .y  (mac_y[g])
        );
        pi_limit #(.YW(YW), .SW(SW)) u_lim (
            .v  (mac_y[g]),
            .lo (st_q.cap.lo),
            .hi (st_q.cap.hi),
            .st (lim_st[g]),
            .y  (lim_y[g])
        );
    end

    assign clip      = (lim_st[0] != pi_pkg::LIM_NONE);
    assign held_clip = (lim_st[1] != pi_pkg::LIM_NONE);

    always_comb begin
        st_d         = st_q;
        st_d.cap.vld = smp_vld;
        if (smp_vld) begin
            st_d.cap.e  = err_in;
            st_d.cap.kp = kp_in;
            st_d.cap.kh = kh_in;
            st_d.cap.lo = lim_lo;
            st_d.cap.hi = lim_hi;
        end
        st_d.vld = 1'b0;
        if (st_q.cap.vld) begin
            st_d.vld    = 1'b1;
            st_d.e_prev = st_q.cap.e;
            if (clip) begin
                st_d.integ = st_q.integ;
                st_d.y     = lim_y[1];
            end else begin
                st_d.integ = integ_new;
                st_d.y     = lim_y[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_vld_q = st_q.cap.vld;
    assign cap_e_q   = st_q.cap.e;
    assign e_prev_q  = st_q.e_prev;
    assign integ_q   = st_q.integ;

    assign ctl_out = st_q.y;
    assign ctl_vld = st_q.vld;

endmodule

// File: rtl/pi_aw_ctrl_chk.sv
module pi_aw_ctrl_chk #(
    parameter int EW    = 16,
    parameter int YW    = 16,
    parameter int ACC_W = 48
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_vld,
    input logic signed [YW-1:0]    lim_lo,
    input logic signed [YW-1:0]    lim_hi,
    input logic signed [YW-1:0]    ctl_out,
    input logic                    ctl_vld,
    input logic                    clip,
    input logic                    held_clip,
    input logic                    cap_vld_q,
    input logic signed [EW-1:0]    cap_e_q,
    input logic signed [EW-1:0]    e_prev_q,
    input logic signed [ACC_W-1:0] integ_q
);

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ##2 ctl_vld);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |-> ##2 !ctl_vld);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_vld |-> $stable(ctl_out));

    p_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_vld |-> (ctl_out <= $past(lim_hi, 2) && ctl_out >= $past(lim_lo, 2)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_vld_q && clip) |=> (integ_q == $past(integ_q)));

    p_clamped_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_vld_q && clip && held_clip) |=>
            (ctl_out == $past(lim_hi, 2) || ctl_out == $past(lim_lo, 2)));

    p_prev_err_r9: assert property (@(posedge clk) disable iff (rst)
        cap_vld_q |=> (e_prev_q == $past(cap_e_q)));

endmodule

bind pi_aw_ctrl pi_aw_ctrl_chk #(.EW(EW), .YW(YW), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .lim_lo    (lim_lo),
    .lim_hi    (lim_hi),
    .ctl_out   (ctl_out),
    .ctl_vld   (ctl_vld),
    .clip      (clip),
    .held_clip (held_clip),
    .cap_vld_q (cap_vld_q),
    .cap_e_q   (cap_e_q),
    .e_prev_q  (e_prev_q),
    .integ_q   (integ_q)
);

// File: tb/pi_aw_ctrl_tb_top.sv
`timescale 1ns/1ps
module pi_aw_ctrl_tb_top;
    localparam int EW    = 16;
    localparam int CW    = 16;
    localparam int YW    = 16;
    localparam int FRAC  = 12;
    localparam int ACC_W = 24;
    localparam longint SMAX = (64'sd1 <<< (ACC_W - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (ACC_W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [EW-1:0] err_in = '0;
    logic signed [CW-1:0] kp_in  = '0;
    logic signed [CW-1:0] kh_in  = '0;
    logic signed [YW-1:0] lim_lo = '0;
    logic signed [YW-1:0] lim_hi = '0;
    logic signed [YW-1:0] ctl_out;
    logic                 ctl_vld;

    always #2 clk = ~clk;

    pi_aw_ctrl #(.EW(EW), .CW(CW), .YW(YW), .FRAC(FRAC), .ACC_W(ACC_W)) dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .err_in(err_in),
        .kp_in(kp_in), .kh_in(kh_in), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .ctl_out(ctl_out), .ctl_vld(ctl_vld)
    );

    typedef struct {
        int     due;
        longint y;
        string  tag;
    } exp_t;

    exp_t   pend[$];
    longint m_s = 0, m_ep = 0, m_y = 0;
    int     cyc = 0;
    int     n_chk = 0, n_err = 0;
    bit     ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input string tag, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            bit    ev;
            string t;
            ev = 1'b0;
            t  = "R8";
            if (pend.size() > 0 && pend[0].due == cyc) begin
                ev  = 1'b1;
                m_y = pend[0].y;
                t   = pend[0].tag;
                void'(pend.pop_front());
            end
            report(ev ? "R2" : t, longint'(ctl_vld), longint'(ev), "valid");
            if ($isunknown(ctl_out))
                report(t, 64'sd9999999, m_y, "output unknown");
            else
                report(t, longint'(ctl_out), m_y, "output");
        end
    end

    function automatic longint model_step(longint e, longint kp, longint kh, longint lo, longint hi);
        longint sn, t;
        sn = m_s + e + m_ep;
        if (sn > SMAX) sn = SMAX;
        if (sn < SMIN) sn = SMIN;
        t = (kp * e + kh * sn) >>> FRAC;
        if (t > hi || t < lo) begin
            sn = m_s;
            t  = (kp * e + kh * m_s) >>> FRAC;
            if (t > hi)      t = hi;
            else if (t < lo) t = lo;
        end
        m_ep = e;
        m_s  = sn;
        return t;
    endfunction

    task automatic smp(input int e, input int kp, input int kh, input int lo, input int hi, input string tag);
        exp_t x;
        @(negedge clk);
        smp_vld = 1'b1;
        err_in  = EW'(e);
        kp_in   = CW'(kp);
        kh_in   = CW'(kh);
        lim_lo  = YW'(lo);
        lim_hi  = YW'(hi);
        x.due = cyc + 2;
        x.y   = model_step(e, kp, kh, lo, hi);
        x.tag = tag;
        pend.push_back(x);
    endtask

    // idle cycles with junk on the data inputs (R8)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1'b0;
            err_in  = EW'($urandom);
            kp_in   = CW'($urandom);
            kh_in   = CW'($urandom);
            lim_lo  = YW'($urandom);
            lim_hi  = YW'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        @(negedge clk);
        m_s = 0; m_ep = 0; m_y = 0;
        pend.delete();
        repeat (2) @(negedge clk);
        report("R1", longint'(ctl_out), 0, "output in reset");
        report("R1", longint'(ctl_vld), 0, "valid in reset");
        rst = 1'b0;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();

        // first sample after reset: zero history (R1), 1000*(1.0)+(0.25)*1000 -> 1250
        smp(1000, 4096, 1024, -30000, 30000, "R1");
        idle(3);

        // trapezoidal sums and the output formula (R3, R4), back to back (R2)
        smp(-500, 4096, 1024, -30000, 30000, "R3");
        smp(200,  4096, 1024, -30000, 30000, "R2");
        smp(-7,   4096, 1024, -30000, 30000, "R2");
        smp(3,    6000, 333,  -30000, 30000, "R4");
        idle(5);
        smp(-1,   4096, 4095, -30000, 30000, "R4");
        idle(2);

        // clipping at the upper limit freezes the integrator (R5, R6)
        smp(3000, 8192, 2048, -5000, 5000, "R5");
        smp(3000, 8192, 2048, -5000, 5000, "R5");
        idle(1);
        smp(3000, 8192, 2048, -5000, 5000, "R6");
        smp(-3000, 8192, 2048, -5000, 5000, "R6");
        smp(-2900, 8192, 2048, -5000, 5000, "R9");
        smp(100,  8192, 2048, -5000, 5000, "R9");
        smp(100,  8192, 2048, -5000, 5000, "R5");
        idle(3);

        // drive the integrator to its positive rail with no output clipping (R7)
        for (int i = 0; i < 140; i++) smp(32767, 0, 0, -32767, 32767, "R7");
        smp(0, 0, 1, -32767, 32767, "R7");
        idle(2);
        for (int i = 0; i < 300; i++) smp(-32768, 0, 0, -32767, 32767, "R7");
        smp(0, 0, 1, -32767, 32767, "R7");
        idle(3);

        // mixed traffic with random gaps
        for (int i = 0; i < 400; i++) begin
            int lo, hi;
            lo = -int'($urandom_range(20000));
            hi = int'($urandom_range(20000));
            smp(int'($signed(16'($urandom))), int'($urandom_range(8192)), int'($urandom_range(8192)),
                lo, hi, "R4");
            idle(int'($urandom_range(2)));
        end
        idle(4);

        // reset in the middle of operation, then a fresh first sample (R1)
        do_reset();
        smp(-1000, 4096, 1024, -30000, 30000, "R1");
        idle(6);
        finish_run();
    end

endmodule